// File: doc/BRIEF.md
# Vector Load/Store Element Address Sequencer

This block takes one vectorised memory request at a time and breaks it into a stream of per-element records. Each record carries a byte address, a destination or source register number, the element index, and a last-element flag. The request states whether the address is formed from base plus immediate or from the sum of two registers. It also carries a vector/scalar tag for the target and for each address operand, an element-stride option, an element size code, a signed immediate, a vector length and three register numbers.

The scalar/vector tags select the access pattern. The pattern is contiguous (unit stride), immediate-strided, a gather of per-element addresses, a select into one register, a splat of one address into many registers, or a plain single access. Register values are fetched through a two-address register-file read port with one cycle of latency. Records leave on a valid/ready stream, and a one-cycle completion pulse marks the end of each request.

Top module: `vld_addr_seq`

## Requirements
- R1: Immediate form, vector target, scalar base, stride option clear: element i has address reg[RA] + sext(imm) + i*size and register RT+i. The size code maps 0→1, 1→2, 2→4, 3→8 bytes.
- R2: Immediate form, vector target, scalar base, stride option set: element i has address reg[RA] + sext(imm)*i, with no size scaling, and register RT+i. The stride option has no effect when the base is a vector or the form is indexed.
- R3: Immediate form, vector target, vector base: element i has address reg[RA+i] + sext(imm) and register RT+i.
- R4: Scalar target with vector RA, in either form: element i has address reg[RA+i] + sext(imm) (immediate form) or reg[RA+i] + reg[RB] (indexed form). Every element uses register RT.
- R5: Indexed form, vector target, vector RB: element i has address reg[RA] + reg[RB] + i*size and register RT+i. This holds whatever the RA tag is.
- R6: Indexed form, vector target, vector RA, scalar RB: element i has address reg[RA+i] + reg[RB] and register RT+i.
- R7: Indexed form, vector target, RA and RB scalar: every element has address reg[RA] + reg[RB] and register RT+i.
- R8: Scalar target with scalar RA: exactly one record is produced, with index 0 and the last flag set. Its address is reg[RA] + sext(imm) or reg[RA] + reg[RB], and its register is RT. The vector length is ignored, including zero.
- R9: A vector request of length zero produces no record. The done output pulses in the cycle after the request is accepted.
- R10: Records carry indices 0 to VL-1 in order, with the last flag only on the final one. Done is high for exactly the one cycle after the final record is accepted.
- R11: req_ready is high only while no request is in progress. While out_valid is high and out_ready is low, the presented record stays unchanged.
- R12: The first record of a request is presented in the second cycle after acceptance. Records follow back to back while out_ready stays high. Register reads return data one cycle after the address is given. Register numbers wrap modulo 32, and addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_indexed | input | 1 | 0: base plus immediate, 1: base plus register |
| req_rt_vec | input | 1 | Target register is a vector |
| req_ra_vec | input | 1 | RA is a vector |
| req_rb_vec | input | 1 | RB is a vector |
| req_elstride | input | 1 | Immediate used as per-element stride |
| req_esz | input | 2 | Element size code |
| req_imm | input | 16 | Signed immediate |
| req_vl | input | 5 | Vector length |
| req_rt | input | 5 | Target register number |
| req_ra | input | 5 | Base register number |
| req_rb | input | 5 | Index register number |
| rf_a_addr | output | 5 | Read address for the RA value |
| rf_b_addr | output | 5 | Read address for the RB value |
| rf_a_data | input | 32 | RA value, one cycle after its address |
| rf_b_data | input | 32 | RB value, one cycle after its address |
| out_valid | output | 1 | Element record valid |
| out_ready | input | 1 | Consumer accepts record |
| out_addr | output | 32 | Element byte address |
| out_reg | output | 5 | Element register number |
| out_idx | output | 5 | Element index |
| out_last | output | 1 | Final record of the request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a stall on the record whose successor's register read is due in the same cycle. When out_ready drops just then, the read address must fall back to the current element so that the returned value still matches the record on display. The bench reaches this case with a long gather whose base register range wraps past register 31. During that gather, out_ready follows a pseudo-random sequence, so stalls land on every element position, including the first record and the last one. Zero-length vector requests and scalar requests with a nonzero length are issued back to back with the other patterns.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    MD_UNIT,
    MD_STRIDE,
    MD_GATHER,
    MD_SELECT,
    MD_SPLAT,
    MD_SINGLE
  } vseq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_EMIT
  } vseq_state_e;
endpackage

// File: rtl/vseq_rst_sync.sv
module vseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vseq_mode_dec.sv
module vseq_mode_dec
  import vseq_pkg::*;
(
  input  logic       indexed,
  input  logic       rt_vec,
  input  logic       ra_vec,
  input  logic       rb_vec,
  input  logic       elstride,
  output vseq_mode_e mode
);
  always_comb begin
    if (!rt_vec) begin
      mode = ra_vec ? MD_SELECT : MD_SINGLE;
    end else if (!indexed) begin
      if (ra_vec)        mode = MD_GATHER;
      else if (elstride) mode = MD_STRIDE;
      else               mode = MD_UNIT;
    end else begin
      if (rb_vec)        mode = MD_UNIT;
      else if (ra_vec)   mode = MD_GATHER;
      else               mode = MD_SPLAT;
    end
  end
endmodule

// File: rtl/vseq_seq_ctrl.sv
module vseq_seq_ctrl
  import vseq_pkg::*;
#(
  parameter int VLW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_single,
  input  logic [VLW-1:0] req_vl,
  input  logic           out_ready,
  output logic           req_ready,
  output logic           accept,
  output logic           out_valid,
  output logic           out_last,
  output logic           done,
  output logic [VLW-1:0] elem_idx,
  output logic [VLW-1:0] read_idx
);
  vseq_state_e    state_q, state_d;
  logic [VLW-1:0] idx_q, idx_d;
  logic [VLW-1:0] total_q, total_d;
  logic [VLW-1:0] req_total;
  logic           done_q, done_d;
  logic           fire;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    out_valid = (state_q == ST_EMIT);
    out_last  = (idx_q == total_q - VLW'(1));
    fire      = out_valid && out_ready;
    req_total = req_single ? VLW'(1) : req_vl;
    state_d   = state_q;
    idx_d     = idx_q;
    total_d   = total_q;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          total_d = req_total;
          idx_d   = '0;
          if (req_total == '0) done_d  = 1'b1;
          else                 state_d = ST_PREP;
        end
      end
      ST_PREP: state_d = ST_EMIT;
      ST_EMIT: begin
        if (fire) begin
          if (out_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + VLW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    read_idx = (fire && !out_last) ? idx_q + VLW'(1) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign elem_idx = idx_q;

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(elem_idx)));

  assert_idx_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && (elem_idx == $past(elem_idx) + VLW'(1))));

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && req_ready));

  assert_first_idx_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (elem_idx == '0));
endmodule

// File: rtl/vseq_addr_calc.sv
module vseq_addr_calc
  import vseq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RW  = 5,
  parameter int VLW = 5,
  parameter int IW  = 16
) (
  input  vseq_mode_e     mode,
  input  logic           indexed,
  input  logic [1:0]     esz,
  input  logic [IW-1:0]  imm,
  input  logic [VLW-1:0] idx,
  input  logic [RW-1:0]  rt,
  input  logic [AW-1:0]  a_data,
  input  logic [AW-1:0]  b_data,
  output logic [AW-1:0]  addr,
  output logic [RW-1:0]  reg_num
);
  logic [AW-1:0] imm_x;
  logic [AW-1:0] idx_x;
  logic [AW-1:0] offset;
  logic [AW-1:0] stride_term;
  logic [AW-1:0] unit_term;

  always_comb begin
    imm_x       = {{(AW-IW){imm[IW-1]}}, imm};
    idx_x       = {{(AW-VLW){1'b0}}, idx};
    offset      = indexed ? b_data : imm_x;
    stride_term = imm_x * idx_x;
    unit_term   = idx_x << esz;
    case (mode)
      MD_UNIT:   addr = a_data + offset + unit_term;
      MD_STRIDE: addr = a_data + stride_term;
      default:   addr = a_data + offset;
    endcase
    if (mode == MD_SELECT || mode == MD_SINGLE) reg_num = rt;
    else                                        reg_num = rt + RW'(idx);
  end
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq
  import vseq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RW  = 5,
  parameter int VLW = 5,
  parameter int IW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_indexed,
  input  logic           req_rt_vec,
  input  logic           req_ra_vec,
  input  logic           req_rb_vec,
  input  logic           req_elstride,
  input  logic [1:0]     req_esz,
  input  logic [IW-1:0]  req_imm,
  input  logic [VLW-1:0] req_vl,
  input  logic [RW-1:0]  req_rt,
  input  logic [RW-1:0]  req_ra,
  input  logic [RW-1:0]  req_rb,
  output logic [RW-1:0]  rf_a_addr,
  output logic [RW-1:0]  rf_b_addr,
  input  logic [AW-1:0]  rf_a_data,
  input  logic [AW-1:0]  rf_b_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic [RW-1:0]  out_reg,
  output logic [VLW-1:0] out_idx,
  output logic           out_last,
  output logic           done
);
  logic           rst_n_s;
  vseq_mode_e     mode_in, mode_q;
  logic           accept;
  logic [VLW-1:0] read_idx;
  logic           indexed_q;
  logic [1:0]     esz_q;
  logic [IW-1:0]  imm_q;
  logic [RW-1:0]  rt_q, ra_q, rb_q;
  logic           ra_stepped;

  vseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vseq_mode_dec u_dec (
    .indexed  (req_indexed),
    .rt_vec   (req_rt_vec),
    .ra_vec   (req_ra_vec),
    .rb_vec   (req_rb_vec),
    .elstride (req_elstride),
    .mode     (mode_in)
  );

  vseq_seq_ctrl #(.VLW(VLW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_single (mode_in == MD_SINGLE),
    .req_vl     (req_vl),
    .out_ready  (out_ready),
    .req_ready  (req_ready),
    .accept     (accept),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .done       (done),
    .elem_idx   (out_idx),
    .read_idx   (read_idx)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q    <= MD_SINGLE;
      indexed_q <= 1'b0;
      esz_q     <= 2'b00;
      imm_q     <= '0;
      rt_q      <= '0;
      ra_q      <= '0;
      rb_q      <= '0;
    end else if (accept) begin
      mode_q    <= mode_in;
      indexed_q <= req_indexed;
      esz_q     <= req_esz;
      imm_q     <= req_imm;
      rt_q      <= req_rt;
      ra_q      <= req_ra;
      rb_q      <= req_rb;
    end
  end

  always_comb begin
    ra_stepped = (mode_q == MD_GATHER) || (mode_q == MD_SELECT);
    rf_a_addr  = ra_stepped ? ra_q + RW'(read_idx) : ra_q;
    rf_b_addr  = rb_q;
  end

  vseq_addr_calc #(.AW(AW), .RW(RW), .VLW(VLW), .IW(IW)) u_calc (
    .mode    (mode_q),
    .indexed (indexed_q),
    .esz     (esz_q),
    .imm     (imm_q),
    .idx     (out_idx),
    .rt      (rt_q),
    .a_data  (rf_a_data),
    .b_data  (rf_b_data),
    .addr    (out_addr),
    .reg_num (out_reg)
  );

  assert_single_once_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && mode_q == MD_SINGLE) |-> (out_last && out_idx == '0));

  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_ready || $stable(rf_a_addr)));
endmodule

// File: tb/tb_vld_addr_seq.sv
module tb_vld_addr_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_indexed = 1'b0, req_rt_vec = 1'b0, req_ra_vec = 1'b0, req_rb_vec = 1'b0, req_elstride = 1'b0;
  logic [1:0]  req_esz = 2'd0;
  logic [15:0] req_imm = 16'd0;
  logic [4:0]  req_vl = 5'd0, req_rt = 5'd0, req_ra = 5'd0, req_rb = 5'd0;
  logic [4:0]  rf_a_addr, rf_b_addr;
  logic [31:0] rf_a_data, rf_b_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [4:0]  out_reg, out_idx;
  logic        out_last, done;

  vld_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_rt_vec(req_rt_vec), .req_ra_vec(req_ra_vec),
    .req_rb_vec(req_rb_vec), .req_elstride(req_elstride), .req_esz(req_esz),
    .req_imm(req_imm), .req_vl(req_vl), .req_rt(req_rt), .req_ra(req_ra), .req_rb(req_rb),
    .rf_a_addr(rf_a_addr), .rf_b_addr(rf_b_addr), .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_reg(out_reg),
    .out_idx(out_idx), .out_last(out_last), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] rf [32];
  always @(posedge clk) begin
    rf_a_data <= rf[rf_a_addr];
    rf_b_data <= rf[rf_b_addr];
  end

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R11";
  bit    mon_en   = 1'b0;
  bit    rnd_en   = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= rnd_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // behavioural reference: expected record queue and cycle state
  logic [31:0] qa[$];
  logic [4:0]  qr[$];
  int          qi[$];
  bit m_valid = 0, m_done = 0;
  int m_cnt = 0;

  task automatic build_expect();
    int n;
    bit single, ra_step, contig, strided;
    logic [31:0] immx, a, b, off, ad;
    single  = !req_rt_vec && !req_ra_vec;
    n       = single ? 1 : int'(req_vl);
    ra_step = req_ra_vec && (!req_rt_vec || !req_indexed || !req_rb_vec);
    strided = req_rt_vec && !req_indexed && !req_ra_vec && req_elstride;
    contig  = req_rt_vec && ((!req_indexed && !req_ra_vec && !req_elstride) ||
                             (req_indexed && req_rb_vec));
    immx = {{16{req_imm[15]}}, req_imm};
    for (int i = 0; i < n; i++) begin
      a   = rf[(int'(req_ra) + (ra_step ? i : 0)) % 32];
      b   = rf[req_rb];
      off = req_indexed ? b : immx;
      if (strided)     ad = a + immx * i;
      else if (contig) ad = a + off + (i << req_esz);
      else             ad = a + off;
      qa.push_back(ad);
      qr.push_back(req_rt_vec ? 5'((int'(req_rt) + i) % 32) : req_rt);
      qi.push_back(i);
    end
  endtask

  always @(posedge clk) begin
    bit idle_now;
    if (!rst_n) begin
      m_valid = 0; m_done = 0; m_cnt = 0;
    end else begin
      idle_now = !m_valid && (m_cnt == 0);
      m_done = 0;
      if (m_valid && out_ready) begin
        void'(qa.pop_front()); void'(qr.pop_front()); void'(qi.pop_front());
        if (qa.size() == 0) begin m_valid = 0; m_done = 1; end
      end
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_valid = 1;
      end
      if (req_valid && idle_now) begin
        build_expect();
        if (qa.size() == 0) m_done = 1;
        else                m_cnt  = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      chk(req_ready == (!m_valid && m_cnt == 0), "R11", "req_ready", 64'(req_ready), 64'(!m_valid && m_cnt == 0));
      chk(out_valid == m_valid, cur_tag, "out_valid", 64'(out_valid), 64'(m_valid));
      chk(done == m_done, cur_tag, "done", 64'(done), 64'(m_done));
      if (m_valid && out_valid) begin
        chk(out_addr == qa[0], cur_tag, "out_addr", 64'(out_addr), 64'(qa[0]));
        chk(out_reg == qr[0], cur_tag, "out_reg", 64'(out_reg), 64'(qr[0]));
        chk(int'(out_idx) == qi[0], cur_tag, "out_idx", 64'(out_idx), 64'(qi[0]));
        chk(out_last == (qa.size() == 1), cur_tag, "out_last", 64'(out_last), 64'(qa.size() == 1));
      end
    end
  end

  task automatic issue(input bit ix, input bit rtv, input bit rav, input bit rbv, input bit els,
                       input logic [1:0] esz, input logic [15:0] imm, input logic [4:0] vl,
                       input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                       input string tag);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    req_indexed = ix; req_rt_vec = rtv; req_ra_vec = rav; req_rb_vec = rbv; req_elstride = els;
    req_esz = esz; req_imm = imm; req_vl = vl; req_rt = rt; req_ra = ra; req_rb = rb;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (m_valid || m_cnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) rf[k] = 32'h0100_0000 + k * 32'h0001_0130 + (k << 3);
    rf[31] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !out_valid && !done, "R11", "reset state", {61'd0, req_ready, out_valid, done}, 64'h4);
    mon_en = 1'b1;

    issue(0,1,0,0,0, 2'd2, 16'd16,     5'd4, 5'd10, 5'd3,  5'd0, "R1");
    issue(0,1,0,0,0, 2'd0, 16'd5,      5'd3, 5'd1,  5'd7,  5'd0, "R1");
    issue(0,1,0,0,0, 2'd3, 16'hFFF8,   5'd4, 5'd30, 5'd31, 5'd0, "R1");
    issue(0,1,0,0,1, 2'd2, 16'd24,     5'd5, 5'd4,  5'd2,  5'd0, "R2");
    issue(0,1,0,0,1, 2'd3, 16'hFFF0,   5'd3, 5'd4,  5'd9,  5'd0, "R2");
    issue(0,1,1,0,0, 2'd2, 16'd8,      5'd5, 5'd30, 5'd29, 5'd0, "R3");
    issue(0,1,1,0,1, 2'd1, 16'd4,      5'd3, 5'd12, 5'd5,  5'd0, "R2");
    issue(0,0,1,0,0, 2'd2, 16'd12,     5'd4, 5'd6,  5'd20, 5'd0, "R4");
    issue(1,0,1,0,0, 2'd2, 16'd0,      5'd3, 5'd6,  5'd20, 5'd8, "R4");
    issue(1,1,0,1,0, 2'd2, 16'd0,      5'd4, 5'd14, 5'd3,  5'd5, "R5");
    issue(1,1,1,1,1, 2'd1, 16'd0,      5'd3, 5'd14, 5'd3,  5'd5, "R5");
    issue(1,1,1,0,0, 2'd3, 16'd0,      5'd4, 5'd0,  5'd28, 5'd2, "R6");
    issue(1,1,0,0,0, 2'd2, 16'd0,      5'd4, 5'd16, 5'd11, 5'd12,"R7");
    issue(0,0,0,0,0, 2'd2, 16'h0040,   5'd7, 5'd9,  5'd13, 5'd0, "R8");
    issue(1,0,0,1,0, 2'd2, 16'd0,      5'd0, 5'd9,  5'd13, 5'd4, "R8");
    issue(0,1,0,0,0, 2'd2, 16'd16,     5'd0, 5'd10, 5'd3,  5'd0, "R9");
    issue(1,1,1,0,0, 2'd2, 16'd0,      5'd0, 5'd10, 5'd3,  5'd1, "R9");
    issue(0,1,0,0,0, 2'd0, 16'd1,      5'd1, 5'd2,  5'd4,  5'd0, "R10");
    rnd_en = 1'b1;
    issue(0,1,1,0,0, 2'd2, 16'd4,      5'd31,5'd20, 5'd25, 5'd0, "R12");
    issue(1,1,0,1,0, 2'd3, 16'd0,      5'd9, 5'd0,  5'd1,  5'd2, "R11");
    issue(0,0,1,0,0, 2'd2, 16'hFFFC,   5'd6, 5'd3,  5'd27, 5'd0, "R11");
    rnd_en = 1'b0;
    issue(0,1,0,0,1, 2'd0, 16'd3,      5'd8, 5'd1,  5'd6,  5'd0, "R12");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL %s watchdog actual=%0d expected=%0d", cur_tag, 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule